// File: doc/BRIEF.md
# Masked Interrupt Status Hub

This block gathers up to twelve event sources into one 16-bit status word, holds each event until software acknowledges it, and raises a single active-high interrupt line whenever an event is pending in a source that is not masked. Eight general-purpose sources arrive as one-cycle set pulses on a vector input. Three timekeeping events (periodic tick, alarm match and time-setting error) each arrive as their own one-cycle pulse. The twelfth source is a push-button level input, and the block records it only when the button goes from released to pressed.

Software reaches the block through a plain byte-wide register port: an address, a write-data byte, a write strobe, and a read-data byte that follows the address combinationally. The 12-bit mask and the 16-bit status each take two byte addresses. Status is read-only and is cleared through two separate write-only acknowledge addresses, where each written one clears the matching status bit. A write with bit 0 set to the power-down address returns the whole block to its reset state.

Top module: `evt_irq_hub`

## Requirements
- R1: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0. It is decoded from the registered mask and status, so it changes in the cycle after the clock edge that updates either one.
- R2: After reset the mask is 0x0FFF, so all twelve sources are masked. The status is 0x0000 and `irq_o` is low.
- R3: Address 0x00 holds mask bits 7..0 and address 0x01 holds mask bits 15..8. A write to one of these bytes leaves the other byte unchanged.
- R4: A write to address 0x04 clears each of status bits 7..0 whose written bit is 1. A write to address 0x05 does the same for status bits 15..8. Status bits whose written bit is 0 are kept. Reading 0x04 or 0x05 returns 0x00.
- R5: Address 0x02 reads status bits 7..0 and address 0x03 reads status bits 15..8. Writes to either address have no effect.
- R6: `gen_evt_i[k]` sets status bit k for k = 0..7. `tick_set_i` sets bit 8, `alarm_set_i` sets bit 9 and `error_set_i` sets bit 10.
- R7: Status bit 11 is set only in the cycle after `button_i` changes from 0 to 1. Holding the button at 1 does not set the bit again after it has been acknowledged.
- R8: When a set event and an acknowledge of the same status bit happen in the same cycle, the bit ends up set.
- R9: Status bits 15..12 and mask bits 15..12 always read as 0 and cannot be set.
- R10: A write to address 0x06 with data bit 0 equal to 1 returns the mask and status to their reset values. This reset takes priority over any set event in the same cycle. A write to 0x06 with data bit 0 equal to 0 has no effect. Reading 0x06 returns 0x00.
- R11: Addresses that are not mapped read as 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register address for both read and write |
| reg_wdata_i | input | 8 | Write data |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| gen_evt_i | input | GEN_N | General event set pulses, one per status bit |
| tick_set_i | input | 1 | Periodic tick set pulse |
| alarm_set_i | input | 1 | Alarm set pulse |
| error_set_i | input | 1 | Time-setting error set pulse |
| button_i | input | 1 | Push-button level |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default of eight general sources. With that setting the named events sit at bits 8 to 11 and bits 12 to 15 are the unused ones. This makes all four regions of the status word reachable: the low byte of general sources, the named events, and the unused high nibble through both the mask and the status addresses. The vector table walks byte-wise masking, partial acknowledges, same-cycle set against acknowledge, and power-down with and without bit 0. Directed tests then walk every general bit on its own and exercise press, hold, acknowledge and re-press on the button.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned STAT_W = 2 * REG_W;

    // Register address map (byte port)
    localparam logic [ADDR_W-1:0] RA_MASK_LO = 8'h00;
    localparam logic [ADDR_W-1:0] RA_MASK_HI = 8'h01;
    localparam logic [ADDR_W-1:0] RA_STAT_LO = 8'h02;
    localparam logic [ADDR_W-1:0] RA_STAT_HI = 8'h03;
    localparam logic [ADDR_W-1:0] RA_ACK_LO  = 8'h04;
    localparam logic [ADDR_W-1:0] RA_ACK_HI  = 8'h05;
    localparam logic [ADDR_W-1:0] RA_OFF     = 8'h06;

    typedef struct packed {
        logic [STAT_W-1:0] mask;
        logic [STAT_W-1:0] stat;
    } irq_state_t;

endpackage

// File: rtl/evt_irq_rise.sv
// Rising-edge detector: one-cycle pulse on each 0->1 change of a level input.
module evt_irq_rise #(
    parameter int unsigned W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/evt_irq_srcmap.sv
// Places every event source at its fixed position in the status word.
module evt_irq_srcmap
    import evt_irq_pkg::*;
#(
    parameter int unsigned GEN_N = 8
) (
    input  logic [GEN_N-1:0]  gen_i,
    input  logic              tick_i,
    input  logic              alarm_i,
    input  logic              error_i,
    input  logic              btn_rise_i,
    output logic [STAT_W-1:0] set_o
);

    localparam int unsigned POS_TICK  = GEN_N;
    localparam int unsigned POS_ALARM = GEN_N + 1;
    localparam int unsigned POS_ERROR = GEN_N + 2;
    localparam int unsigned POS_BTN   = GEN_N + 3;

    logic [STAT_W-1:0] gen_part;

    for (genvar k = 0; k < STAT_W; k++) begin : g_gen
        if (k < GEN_N) begin : g_used
            assign gen_part[k] = gen_i[k];
        end else begin : g_zero
            assign gen_part[k] = 1'b0;
        end
    end

    always_comb begin
        set_o            = gen_part;
        set_o[POS_TICK]  = tick_i;
        set_o[POS_ALARM] = alarm_i;
        set_o[POS_ERROR] = error_i;
        set_o[POS_BTN]   = btn_rise_i;
    end

endmodule

// File: rtl/evt_irq_core.sv
// Mask and status registers with byte writes, acknowledge and power-down reset.
module evt_irq_core
    import evt_irq_pkg::*;
#(
    parameter int unsigned GEN_N = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [STAT_W-1:0] set_i,
    output logic [STAT_W-1:0] mask_o,
    output logic [STAT_W-1:0] stat_o
);

    localparam int unsigned     SRC_N = GEN_N + 4;
    localparam logic [STAT_W-1:0] VALID = STAT_W'((33'd1 << SRC_N) - 33'd1);
    localparam irq_state_t      RST_VAL = '{mask: VALID, stat: '0};

    irq_state_t        st_d, st_q;
    logic [STAT_W-1:0] ack_vec;
    logic              off_hit;

    always_comb begin
        st_d    = st_q;
        ack_vec = '0;
        off_hit = 1'b0;
        if (wr_en_i) begin
            case (wr_addr_i)
                RA_MASK_LO: st_d.mask[REG_W-1:0]      = wr_data_i;
                RA_MASK_HI: st_d.mask[STAT_W-1:REG_W] = wr_data_i;
                RA_ACK_LO:  ack_vec[REG_W-1:0]        = wr_data_i;
                RA_ACK_HI:  ack_vec[STAT_W-1:REG_W]   = wr_data_i;
                RA_OFF:     off_hit                   = wr_data_i[0];
                default:    ;
            endcase
        end
        st_d.mask = st_d.mask & VALID;
        // a set in the same cycle overrides its acknowledge
        st_d.stat = ((st_q.stat & ~ack_vec) | set_i) & VALID;
        if (off_hit) begin
            st_d = RST_VAL;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RST_VAL;
        else         st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign stat_o = st_q.stat;

endmodule

// File: rtl/evt_irq_rdmux.sv
// Combinational byte read selection.
module evt_irq_rdmux
    import evt_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [STAT_W-1:0] mask_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [REG_W-1:0]  rdata_o
);

    always_comb begin
        case (addr_i)
            RA_MASK_LO: rdata_o = mask_i[REG_W-1:0];
            RA_MASK_HI: rdata_o = mask_i[STAT_W-1:REG_W];
            RA_STAT_LO: rdata_o = stat_i[REG_W-1:0];
            RA_STAT_HI: rdata_o = stat_i[STAT_W-1:REG_W];
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
    import evt_irq_pkg::*;
#(
    parameter int unsigned GEN_N = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    input  logic              reg_we_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic [GEN_N-1:0]  gen_evt_i,
    input  logic              tick_set_i,
    input  logic              alarm_set_i,
    input  logic              error_set_i,
    input  logic              button_i,
    output logic              irq_o
);

    logic              btn_rise;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] mask_w;
    logic [STAT_W-1:0] stat_w;

    evt_irq_rise #(.W(1)) i_btn_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (button_i),
        .rise_o (btn_rise)
    );

    evt_irq_srcmap #(.GEN_N(GEN_N)) i_srcmap (
        .gen_i      (gen_evt_i),
        .tick_i     (tick_set_i),
        .alarm_i    (alarm_set_i),
        .error_i    (error_set_i),
        .btn_rise_i (btn_rise),
        .set_o      (set_vec)
    );

    evt_irq_core #(.GEN_N(GEN_N)) i_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (reg_we_i),
        .wr_addr_i (reg_addr_i),
        .wr_data_i (reg_wdata_i),
        .set_i     (set_vec),
        .mask_o    (mask_w),
        .stat_o    (stat_w)
    );

    evt_irq_rdmux i_rdmux (
        .addr_i  (reg_addr_i),
        .mask_i  (mask_w),
        .stat_i  (stat_w),
        .rdata_o (reg_rdata_o)
    );

    assign irq_o = |(stat_w & ~mask_w);

endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk
    import evt_irq_pkg::*;
#(
    parameter int unsigned GEN_N = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [REG_W-1:0]  reg_wdata_i,
    input logic              reg_we_i,
    input logic [REG_W-1:0]  reg_rdata_o,
    input logic [GEN_N-1:0]  gen_evt_i,
    input logic              tick_set_i,
    input logic              button_i,
    input logic              irq_o,
    input logic [STAT_W-1:0] mask_w,
    input logic [STAT_W-1:0] stat_w
);

    localparam int unsigned       SRC_N = GEN_N + 4;
    localparam logic [STAT_W-1:0] VALID = STAT_W'((33'd1 << SRC_N) - 33'd1);

    logic              off_wr;
    logic [STAT_W-1:0] gen_pad;

    assign off_wr  = reg_we_i && (reg_addr_i == RA_OFF) && reg_wdata_i[0];
    assign gen_pad = STAT_W'(gen_evt_i);

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mask_w & VALID) == VALID) |-> !irq_o); // R1

    AST_MASK_LO_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_addr_i == RA_MASK_LO && !off_wr)
        |=> (mask_w[STAT_W-1:REG_W] == $past(mask_w[STAT_W-1:REG_W]))); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_addr_i == RA_ACK_LO)
        |=> ((stat_w[REG_W-1:0] & $past(reg_wdata_i & ~gen_pad[REG_W-1:0])) == '0)); // R4

    AST_ACK_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == RA_ACK_LO || reg_addr_i == RA_ACK_HI) |-> (reg_rdata_o == '0)); // R4

    AST_BTN_PRESS_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(button_i) && !off_wr) |=> stat_w[GEN_N+3]); // R7

    AST_SET_BEATS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_set_i && !off_wr) |=> stat_w[GEN_N]); // R8

    AST_UPPER_NIBBLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == RA_STAT_HI || reg_addr_i == RA_MASK_HI)
        |-> (reg_rdata_o[REG_W-1:SRC_N-REG_W] == '0)); // R9

    AST_POWER_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        off_wr |=> (!irq_o && stat_w == '0 && mask_w == VALID)); // R10

endmodule

bind evt_irq_hub evt_irq_hub_chk #(.GEN_N(GEN_N)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_we_i    (reg_we_i),
    .reg_rdata_o (reg_rdata_o),
    .gen_evt_i   (gen_evt_i),
    .tick_set_i  (tick_set_i),
    .button_i    (button_i),
    .irq_o       (irq_o),
    .mask_w      (mask_w),
    .stat_w      (stat_w)
);

// File: tb/test_evt_irq_hub.sv
module test_evt_irq_hub;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [7:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic       reg_we_i = 1'b0;
    logic [7:0] reg_rdata_o;
    logic [7:0] gen_evt_i = '0;
    logic       tick_set_i = 1'b0;
    logic       alarm_set_i = 1'b0;
    logic       error_set_i = 1'b0;
    logic       button_i = 1'b0;
    logic       irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk_i = ~clk_i; // 50 MHz

    evt_irq_hub #(.GEN_N(8)) i_evt_irq_hub (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_we_i    (reg_we_i),
        .reg_rdata_o (reg_rdata_o),
        .gen_evt_i   (gen_evt_i),
        .tick_set_i  (tick_set_i),
        .alarm_set_i (alarm_set_i),
        .error_set_i (error_set_i),
        .button_i    (button_i),
        .irq_o       (irq_o)
    );

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic [7:0] gen;
        logic       tick;
        logic       alm;
        logic       err;
        logic [7:0] rd_addr;
        logic [7:0] exp_rd;
        logic       exp_irq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R3 unmask low byte
        '{1'b0, 8'h00, 8'h00, 8'h05, 1'b0, 1'b0, 1'b0, 8'h02, 8'h05, 1'b1}, // R1 R6 general events
        '{1'b1, 8'h04, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02, 8'h04, 1'b1}, // R4 partial ack
        '{1'b1, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1}, // R3 high write keeps low
        '{1'b1, 8'h04, 8'h04, 8'h00, 1'b1, 1'b0, 1'b1, 8'h03, 8'h05, 1'b1}, // R6 tick and error
        '{1'b1, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b1}, // R1 high byte still open
        '{1'b1, 8'h01, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'h0F, 1'b0}, // R9 mask top nibble
        '{1'b1, 8'h03, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h03, 8'h05, 1'b0}, // R5 status read-only
        '{1'b1, 8'h05, 8'h02, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 8'h07, 1'b0}, // R8 set beats ack
        '{1'b1, 8'h05, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h03, 8'h00, 1'b0}, // R4 R9 full ack high
        '{1'b1, 8'h00, 8'h3C, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0}, // R3 mask pattern
        '{1'b1, 8'h06, 8'hFE, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0}, // R10 bit0 clear no effect
        '{1'b0, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h04, 8'h00, 1'b1}, // R4 ack reads zero
        '{1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02, 8'hFF, 1'b1}, // R5 status low byte
        '{1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h06, 8'h00, 1'b1}, // R10 off reads zero
        '{1'b1, 8'h06, 8'h01, 8'h01, 1'b1, 1'b0, 1'b0, 8'h02, 8'h00, 1'b0}, // R10 power-down beats set
        '{1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'h0F, 1'b0}, // R10 mask restored
        '{1'b1, 8'h3F, 8'hAA, 8'h00, 1'b0, 1'b0, 1'b0, 8'h3F, 8'h00, 1'b0}  // R11 unmapped address
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic apply(input logic we, input logic [7:0] addr, input logic [7:0] wdata,
                         input logic [7:0] gen, input logic t, input logic a, input logic e);
        @(negedge clk_i);
        reg_we_i    = we;
        reg_addr_i  = addr;
        reg_wdata_i = wdata;
        gen_evt_i   = gen;
        tick_set_i  = t;
        alarm_set_i = a;
        error_set_i = e;
        @(posedge clk_i);
        @(negedge clk_i);
        reg_we_i    = 1'b0;
        gen_evt_i   = '0;
        tick_set_i  = 1'b0;
        alarm_set_i = 1'b0;
        error_set_i = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [7:0] addr,
                            input logic [7:0] exp, input logic exp_irq);
        reg_addr_i = addr;
        #1;
        check(req, reg_rdata_o, exp);
        check({req, " irq"}, {7'b0, irq_o}, {7'b0, exp_irq});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R2 reset state
        read_chk("R2", 8'h00, 8'hFF, 1'b0);
        read_chk("R2", 8'h01, 8'h0F, 1'b0);
        read_chk("R2", 8'h02, 8'h00, 1'b0);
        read_chk("R2", 8'h03, 8'h00, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].gen,
                  VEC[i].tick, VEC[i].alm, VEC[i].err);
            read_chk($sformatf("vector %0d", i), VEC[i].rd_addr, VEC[i].exp_rd, VEC[i].exp_irq);
        end

        // R6 walk each general bit on its own, low byte unmasked
        apply(1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            apply(1'b0, 8'h00, 8'h00, 8'(1 << k), 1'b0, 1'b0, 1'b0);
            read_chk("R6 walk", 8'h02, 8'(1 << k), 1'b1);
            apply(1'b1, 8'h04, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0);
            read_chk("R4 walk ack", 8'h02, 8'h00, 1'b0);
        end

        // R7 button: press sets bit 11, hold does not re-set, re-press does
        apply(1'b1, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        @(negedge clk_i);
        button_i = 1'b1;
        @(posedge clk_i);
        @(negedge clk_i);
        read_chk("R7 press", 8'h03, 8'h08, 1'b1);
        apply(1'b1, 8'h05, 8'h08, 8'h00, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk_i);
        read_chk("R7 hold", 8'h03, 8'h00, 1'b0);
        button_i = 1'b0;
        repeat (2) @(negedge clk_i);
        read_chk("R7 release", 8'h03, 8'h00, 1'b0);
        button_i = 1'b1;
        @(posedge clk_i);
        @(negedge clk_i);
        read_chk("R7 re-press", 8'h03, 8'h08, 1'b1);

        // R1 masking bit 11 alone drops the request, status kept
        apply(1'b1, 8'h01, 8'h08, 8'h00, 1'b0, 1'b0, 1'b0);
        read_chk("R1 masked", 8'h03, 8'h08, 1'b0);

        finish_run();
    end

endmodule